// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block sits at the host-facing edge of a small NAND flash device model. On every write strobe it samples an 8-bit data bus together with a chip select (active low), a command-latch enable and an address-latch enable. Command bytes are decoded into a command register and an optional column offset. Address bytes are stacked, least significant first, into a wide address register. The block then tells the downstream page, status and ID logic exactly when to act by pulsing an execute strobe tagged with an opcode.

Some opcodes act on the write that delivers them. Others wait until a set number of address bytes has arrived. That number depends on the opcode and on the page geometry, which is chosen by parameters: small pages, large pages on devices of 1 Gbit or less, or large pages on larger devices. Two read aliases fold into the plain read opcode with a preset column offset. In large-page mode, a column-reselect opcode rewrites only the low part of the address. The array, the page buffer and the status and ID bytes live in other blocks.

Top module: `nand_cmd_seq`

## Requirements
- R1: A write is a command byte only when `chip_sel_n`=0 and `cmd_latch_en`=1. It is an address byte when `addr_latch_en`=1 and it is not a command byte; chip select does not gate address bytes. With no write strobe, nothing changes and no strobe fires.
- R2: After reset the command is 0x00, the address and column offset are zero, the byte count is zero, and both strobes are low.
- R3: Command 0x00 sets the column offset to 0. Command 0x01 sets it to 0x100 and command 0x50 sets it to PAGE_BYTES; both of these are stored as command 0x00.
- R4: Commands 0x10, 0x35, 0x60, 0x70, 0xD0, 0xE0 and 0xFF raise `exec_stb` for one cycle right after the write, with `exec_op` equal to the command byte.
- R5: Latching any command other than 0xE0 clears the address byte count. 0xE0 keeps it, so the next address byte continues at the following byte lane.
- R6: An address byte lands at bits [8n+7:8n], where n is the byte count, and the count then increments. Bytes arriving after ADDR_BYTES have been taken are dropped.
- R7: With command 0x90 stored, the first address byte raises `exec_stb` with `exec_op`=0x90.
- R8: With command 0x00 or 0x80 stored, `exec_stb` fires with that opcode on address byte 3 in small-page mode, on byte 4 in large-page mode with BIG_DEVICE=0, and on byte 5 in large-page mode with BIG_DEVICE=1.
- R9: In large-page mode, 0x30 received while the stored command is 0x00 is ignored: the command, address and count do not change and no strobe fires.
- R10: In large-page mode, 0x05 clears the low 16 address bits and the byte count, leaves the command unchanged and fires no strobe. In small-page mode, 0x05 is simply latched.
- R11: Command 0xD0 keeps only the address bytes received so far, shifts the result left by 8 bits (small-page mode) or 16 bits (large-page mode), and fires `exec_stb` with opcode 0xD0.
- R12: Command 0xFF sets the command to 0x00 and clears the address, the column offset and the byte count, and fires `exec_stb` with opcode 0xFF.
- R13: The recognised set is 0x00, 0x01, 0x05, 0x10, 0x15, 0x30, 0x35, 0x50, 0x60, 0x70, 0x80, 0x85, 0x90, 0xD0, 0xE0 and 0xFF. Any other command byte is latched, fires no execute strobe, and raises `unknown_stb` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Bus write strobe, one cycle per byte |
| chip_sel_n | input | 1 | Chip select, active low |
| cmd_latch_en | input | 1 | Marks the byte as a command |
| addr_latch_en | input | 1 | Marks the byte as an address byte |
| io_in | input | 8 | Data bus byte |
| cmd_out | output | 8 | Stored command |
| addr_out | output | 8*ADDR_BYTES | Assembled address |
| col_out | output | COL_W | Column offset preset by the read commands |
| exec_stb | output | 1 | One-cycle execute request |
| exec_op | output | 8 | Opcode for the execute request |
| unknown_stb | output | 1 | One-cycle flag for an unrecognised command |

## Verification
The bench builds three copies side by side on shared inputs. The first uses large pages on a device of 1 Gbit or less, with 2048-byte pages and five address bytes. The second uses small pages with 512-byte pages and four address bytes. The third uses large pages on a larger device. Together they cover all three trigger positions for the read and program commands, the mode-dependent handling of 0x05 and 0x30, and both erase shift amounts. The five-byte copy also allows the overflow case, where a sixth byte must be dropped.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef enum logic [7:0] {
      OP_READ0     = 8'h00,
      OP_READ1     = 8'h01,
      OP_RDCOL     = 8'h05,
      OP_PROG_GO   = 8'h10,
      OP_CACHE_GO  = 8'h15,
      OP_READ_GO   = 8'h30,
      OP_RDCOPY_GO = 8'h35,
      OP_READ2     = 8'h50,
      OP_ERASE_SET = 8'h60,
      OP_STATUS    = 8'h70,
      OP_PROG_SET  = 8'h80,
      OP_COPY_SET  = 8'h85,
      OP_IDENT     = 8'h90,
      OP_ERASE_GO  = 8'hD0,
      OP_RDCOL_GO  = 8'hE0,
      OP_RESET     = 8'hFF
   } nand_op_e;

   // opcodes that act on the write that carries them
   function automatic logic op_acts_now(input logic [7:0] v);
      case (v)
         OP_STATUS, OP_PROG_GO, OP_ERASE_SET, OP_ERASE_GO,
         OP_RDCOPY_GO, OP_RDCOL_GO, OP_RESET: op_acts_now = 1'b1;
         default:                             op_acts_now = 1'b0;
      endcase
   endfunction

   function automatic logic op_known(input logic [7:0] v);
      case (v)
         OP_READ0, OP_READ1, OP_RDCOL, OP_PROG_GO, OP_CACHE_GO, OP_READ_GO,
         OP_RDCOPY_GO, OP_READ2, OP_ERASE_SET, OP_STATUS, OP_PROG_SET,
         OP_COPY_SET, OP_IDENT, OP_ERASE_GO, OP_RDCOL_GO, OP_RESET:
                  op_known = 1'b1;
         default: op_known = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
   import nand_seq_pkg::*;
#(
   parameter int LARGE_PAGE = 1,
   parameter int PAGE_BYTES = 2048,
   parameter int COL_W      = 16
) (
   input  logic             cmd_byte,
   input  logic [7:0]       din,
   input  logic [7:0]       cur_cmd,
   output logic             latch_cmd,
   output logic [7:0]       nxt_cmd,
   output logic             load_col,
   output logic [COL_W-1:0] nxt_col,
   output logic             fire_now,
   output logic             unknown,
   output logic             clr_cnt,
   output logic             col_clear,
   output logic             erase_fix,
   output logic             wipe
);

   logic lp_skip, lp_colsel;

   generate
      if (LARGE_PAGE != 0) begin : g_lp
         assign lp_skip   = (cur_cmd == OP_READ0) && (din == OP_READ_GO);
         assign lp_colsel = (din == OP_RDCOL);
      end else begin : g_sp
         assign lp_skip   = 1'b0;
         assign lp_colsel = 1'b0;
      end
   endgenerate

   always_comb begin
      latch_cmd = 1'b0;
      nxt_cmd   = din;
      load_col  = 1'b0;
      nxt_col   = '0;
      fire_now  = 1'b0;
      unknown   = 1'b0;
      clr_cnt   = 1'b0;
      col_clear = 1'b0;
      erase_fix = 1'b0;
      wipe      = 1'b0;
      if (cmd_byte && !lp_skip) begin
         if (lp_colsel) begin
            col_clear = 1'b1;
         end else begin
            latch_cmd = 1'b1;
            case (din)
               OP_READ0: load_col = 1'b1;
               OP_READ1: begin
                  load_col = 1'b1;
                  nxt_col  = COL_W'(256);
                  nxt_cmd  = OP_READ0;
               end
               OP_READ2: begin
                  load_col = 1'b1;
                  nxt_col  = COL_W'(PAGE_BYTES);
                  nxt_cmd  = OP_READ0;
               end
               default: ;
            endcase
            fire_now  = op_acts_now(din);
            unknown   = !op_known(din);
            clr_cnt   = (din != OP_RDCOL_GO);
            erase_fix = (din == OP_ERASE_GO);
            wipe      = (din == OP_RESET);
         end
      end
   end

endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect #(
   parameter int ADDR_BYTES  = 5,
   parameter int ROW_SHIFT   = 16,
   localparam int ADDR_W     = 8 * ADDR_BYTES,
   localparam int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_ok,
   input  logic [7:0]        din,
   input  logic              clr_cnt,
   input  logic              col_clear,
   input  logic              erase_fix,
   input  logic              wipe,
   output logic              took,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q
);

   localparam logic [ADDR_W-1:0] KEEP_ROW =
      {{(ADDR_W-ROW_SHIFT){1'b1}}, {ROW_SHIFT{1'b0}}};

   logic [ADDR_W-1:0] put, kept, erased;

   always_comb begin
      took = byte_ok && (cnt_q < CNT_W'(ADDR_BYTES));
      put  = addr_q;
      for (int i = 0; i < ADDR_BYTES; i++) begin
         if (cnt_q == CNT_W'(i)) put[8*i +: 8] = din;
      end
   end

   generate
      for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_keep
         assign kept[8*g +: 8] = (cnt_q > CNT_W'(g)) ? addr_q[8*g +: 8] : 8'h00;
      end
   endgenerate

   assign erased = kept << ROW_SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (wipe) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (col_clear) begin
         addr_q <= addr_q & KEEP_ROW;
         cnt_q  <= '0;
      end else if (erase_fix) begin
         addr_q <= erased;
         cnt_q  <= '0;
      end else if (clr_cnt) begin
         cnt_q  <= '0;
      end else if (took) begin
         addr_q <= put;
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   // R6
   cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(ADDR_BYTES));

   // R5
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cnt |=> (cnt_q == '0));

   // R6
   drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ok && cnt_q == CNT_W'(ADDR_BYTES) && !clr_cnt && !wipe && !col_clear && !erase_fix)
         |=> $stable(addr_q));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nand_seq_pkg::*;
#(
   parameter int LARGE_PAGE = 1,
   parameter int BIG_DEVICE = 0,
   parameter int PAGE_BYTES = 2048,
   parameter int ADDR_BYTES = 5,
   parameter int COL_W      = 16,
   localparam int ADDR_W    = 8 * ADDR_BYTES,
   localparam int CNT_W     = $clog2(ADDR_BYTES + 1),
   localparam int ROW_SHIFT = (LARGE_PAGE != 0) ? 16 : 8,
   localparam int TRIG      = (LARGE_PAGE == 0) ? 3 : ((BIG_DEVICE != 0) ? 5 : 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              chip_sel_n,
   input  logic              cmd_latch_en,
   input  logic              addr_latch_en,
   input  logic [7:0]        io_in,
   output logic [7:0]        cmd_out,
   output logic [ADDR_W-1:0] addr_out,
   output logic [COL_W-1:0]  col_out,
   output logic              exec_stb,
   output logic [7:0]        exec_op,
   output logic              unknown_stb
);

   generate
      if (ADDR_BYTES < TRIG) begin : g_bad_bytes
         $error("ADDR_BYTES too small for the read trigger position");
      end
      if (PAGE_BYTES >= (1 << COL_W)) begin : g_bad_col
         $error("PAGE_BYTES does not fit in COL_W");
      end
      if (ADDR_W <= ROW_SHIFT) begin : g_bad_shift
         $error("address narrower than the erase shift");
      end
   endgenerate

   logic             cmd_byte, byte_ok, took;
   logic             latch_cmd, load_col, fire_now, unknown, clr_cnt;
   logic             col_clear, erase_fix, wipe;
   logic [7:0]       nxt_cmd, cmd_q;
   logic [COL_W-1:0] nxt_col, col_q;
   logic [CNT_W-1:0] cnt;
   logic             fire_addr;

   assign cmd_byte = wr_stb && !chip_sel_n && cmd_latch_en;
   assign byte_ok  = wr_stb && addr_latch_en && !cmd_byte;

   nand_cmd_decode #(
      .LARGE_PAGE (LARGE_PAGE),
      .PAGE_BYTES (PAGE_BYTES),
      .COL_W      (COL_W)
   ) u_dec (
      .cmd_byte  (cmd_byte),
      .din       (io_in),
      .cur_cmd   (cmd_q),
      .latch_cmd (latch_cmd),
      .nxt_cmd   (nxt_cmd),
      .load_col  (load_col),
      .nxt_col   (nxt_col),
      .fire_now  (fire_now),
      .unknown   (unknown),
      .clr_cnt   (clr_cnt),
      .col_clear (col_clear),
      .erase_fix (erase_fix),
      .wipe      (wipe)
   );

   nand_addr_collect #(
      .ADDR_BYTES (ADDR_BYTES),
      .ROW_SHIFT  (ROW_SHIFT)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_ok   (byte_ok),
      .din       (io_in),
      .clr_cnt   (clr_cnt),
      .col_clear (col_clear),
      .erase_fix (erase_fix),
      .wipe      (wipe),
      .took      (took),
      .addr_q    (addr_out),
      .cnt_q     (cnt)
   );

   always_comb begin
      fire_addr = 1'b0;
      if (took) begin
         if (cnt == CNT_W'(0) && cmd_q == OP_IDENT) fire_addr = 1'b1;
         if (cnt == CNT_W'(TRIG - 1) &&
             (cmd_q == OP_READ0 || cmd_q == OP_PROG_SET)) fire_addr = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q       <= OP_READ0;
         col_q       <= '0;
         exec_stb    <= 1'b0;
         exec_op     <= 8'h00;
         unknown_stb <= 1'b0;
      end else begin
         unknown_stb <= unknown;
         if (wipe) begin
            cmd_q <= OP_READ0;
            col_q <= '0;
         end else begin
            if (latch_cmd) cmd_q <= nxt_cmd;
            if (load_col)  col_q <= nxt_col;
         end
         if (fire_now) begin
            exec_stb <= 1'b1;
            exec_op  <= io_in;
         end else if (fire_addr) begin
            exec_stb <= 1'b1;
            exec_op  <= cmd_q;
         end else begin
            exec_stb <= 1'b0;
         end
      end
   end

   assign cmd_out = cmd_q;
   assign col_out = col_q;

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ($stable(cmd_q) && $stable(col_q) && $stable(addr_out) && !exec_stb));

   // R13
   unk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unknown_stb |-> !exec_stb);

   // R7
   ident_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && exec_op == OP_IDENT) |-> (cnt == CNT_W'(1)));

   // R8
   read_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && (exec_op == OP_READ0 || exec_op == OP_PROG_SET))
         |-> (cnt == CNT_W'(TRIG)));

endmodule

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_stb = 1'b0, chip_sel_n = 1'b1, cmd_latch_en = 1'b0, addr_latch_en = 1'b0;
   logic [7:0] io_in = 8'h00;

   always #5 clk = ~clk;

   logic [7:0]  l_cmd, l_op, s_cmd, s_op, b_cmd, b_op;
   logic [39:0] l_addr, b_addr;
   logic [31:0] s_addr;
   logic [15:0] l_col, s_col, b_col;
   logic        l_ex, l_unk, s_ex, s_unk, b_ex, b_unk;

   nand_cmd_seq #(.LARGE_PAGE(1), .BIG_DEVICE(0), .PAGE_BYTES(2048), .ADDR_BYTES(5)) u_nand_cmd_seq (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .chip_sel_n(chip_sel_n),
      .cmd_latch_en(cmd_latch_en), .addr_latch_en(addr_latch_en), .io_in(io_in),
      .cmd_out(l_cmd), .addr_out(l_addr), .col_out(l_col),
      .exec_stb(l_ex), .exec_op(l_op), .unknown_stb(l_unk));

   nand_cmd_seq #(.LARGE_PAGE(0), .BIG_DEVICE(0), .PAGE_BYTES(512), .ADDR_BYTES(4)) u_small (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .chip_sel_n(chip_sel_n),
      .cmd_latch_en(cmd_latch_en), .addr_latch_en(addr_latch_en), .io_in(io_in),
      .cmd_out(s_cmd), .addr_out(s_addr), .col_out(s_col),
      .exec_stb(s_ex), .exec_op(s_op), .unknown_stb(s_unk));

   nand_cmd_seq #(.LARGE_PAGE(1), .BIG_DEVICE(1), .PAGE_BYTES(2048), .ADDR_BYTES(5)) u_big (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .chip_sel_n(chip_sel_n),
      .cmd_latch_en(cmd_latch_en), .addr_latch_en(addr_latch_en), .io_in(io_in),
      .cmd_out(b_cmd), .addr_out(b_addr), .col_out(b_col),
      .exec_stb(b_ex), .exec_op(b_op), .unknown_stb(b_unk));

   int total = 0;
   int bad   = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // one bus write; returns at the following falling edge
   task automatic wr(input logic cs_n, input logic cl, input logic al, input logic [7:0] d);
      @(negedge clk);
      wr_stb = 1'b1; chip_sel_n = cs_n; cmd_latch_en = cl; addr_latch_en = al; io_in = d;
      @(negedge clk);
      wr_stb = 1'b0; chip_sel_n = 1'b1; cmd_latch_en = 1'b0; addr_latch_en = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] d);
      wr(1'b0, 1'b1, 1'b0, d);
   endtask

   task automatic adr(input logic [7:0] d);
      wr(1'b0, 1'b0, 1'b1, d);
   endtask

   // vector: cs_n cl al data | exec op unk cmd col   (large-page copy)
   localparam int NV = 20;
   localparam logic [44:0] VEC [NV] = '{
      {1'b0,1'b1,1'b0,8'h70, 1'b1,8'h70,1'b0,8'h70,16'h0000},  // R4
      {1'b1,1'b1,1'b0,8'h10, 1'b0,8'h00,1'b0,8'h70,16'h0000},  // R1
      {1'b0,1'b1,1'b0,8'h00, 1'b0,8'h00,1'b0,8'h00,16'h0000},  // R3
      {1'b0,1'b0,1'b1,8'h11, 1'b0,8'h00,1'b0,8'h00,16'h0000},
      {1'b0,1'b0,1'b1,8'h22, 1'b0,8'h00,1'b0,8'h00,16'h0000},
      {1'b0,1'b0,1'b1,8'h33, 1'b0,8'h00,1'b0,8'h00,16'h0000},
      {1'b0,1'b0,1'b1,8'h44, 1'b1,8'h00,1'b0,8'h00,16'h0000},  // R8
      {1'b0,1'b1,1'b0,8'h30, 1'b0,8'h00,1'b0,8'h00,16'h0000},  // R9
      {1'b0,1'b1,1'b0,8'h01, 1'b0,8'h00,1'b0,8'h00,16'h0100},  // R3
      {1'b0,1'b1,1'b0,8'h50, 1'b0,8'h00,1'b0,8'h00,16'h0800},  // R3
      {1'b0,1'b1,1'b0,8'h90, 1'b0,8'h00,1'b0,8'h90,16'h0800},
      {1'b0,1'b0,1'b1,8'h00, 1'b1,8'h90,1'b0,8'h90,16'h0800},  // R7
      {1'b0,1'b1,1'b0,8'hAB, 1'b0,8'h00,1'b1,8'hAB,16'h0800},  // R13
      {1'b0,1'b1,1'b0,8'h35, 1'b1,8'h35,1'b0,8'h35,16'h0800},  // R4
      {1'b0,1'b1,1'b0,8'h80, 1'b0,8'h00,1'b0,8'h80,16'h0800},
      {1'b0,1'b0,1'b1,8'h01, 1'b0,8'h00,1'b0,8'h80,16'h0800},
      {1'b0,1'b0,1'b1,8'h02, 1'b0,8'h00,1'b0,8'h80,16'h0800},
      {1'b0,1'b0,1'b1,8'h03, 1'b0,8'h00,1'b0,8'h80,16'h0800},
      {1'b0,1'b0,1'b1,8'h04, 1'b1,8'h80,1'b0,8'h80,16'h0800},  // R8
      {1'b0,1'b1,1'b0,8'h15, 1'b0,8'h00,1'b0,8'h15,16'h0800}   // R13 known, no exec
   };

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R2 watchdog act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk("R2 reset", {l_cmd, l_addr, l_col, l_ex, l_unk}, {8'h00, 40'h0, 16'h0, 1'b0, 1'b0});

      for (int i = 0; i < NV; i++) begin
         logic [44:0] v;
         logic [7:0]  op_act;
         v = VEC[i];
         wr(v[44], v[43], v[42], v[41:34]);
         op_act = v[33] ? l_op : 8'h00;
         chk($sformatf("R1/R3/R4/R7/R8/R9/R13 vec%0d", i),
             {l_ex, op_act, l_unk, l_cmd, l_col}, v[33:0]);
      end

      // R6 assembly and overflow drop
      cmd(8'h00);
      adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); adr(8'h05);
      chk("R6 five bytes", l_addr, 40'h0504030201);
      adr(8'h06);
      chk("R6 sixth dropped", {l_addr, l_ex}, {40'h0504030201, 1'b0});

      // R10 column reselect in large-page mode
      cmd(8'h05);
      chk("R10 col clear", {l_addr, l_cmd, l_ex, l_unk}, {40'h0504030000, 8'h00, 1'b0, 1'b0});
      adr(8'hAA); adr(8'hBB);
      chk("R10 count restart", l_addr, 40'h050403BBAA);

      // R5 0xE0 keeps the count
      cmd(8'hE0);
      chk("R4 E0 fires", {l_ex, l_op, l_cmd}, {1'b1, 8'hE0, 8'hE0});
      adr(8'hCC);
      chk("R5 E0 keeps count", l_addr, 40'h0504CCBBAA);

      // R11 erase confirm, large page
      cmd(8'h60);
      adr(8'h12); adr(8'h34);
      cmd(8'hD0);
      chk("R11 erase large", {l_addr, l_ex, l_op}, {40'h0034120000, 1'b1, 8'hD0});

      // R12 reset command
      cmd(8'h50);
      chk("R3 col before reset", l_col, 16'h0800);
      cmd(8'hFF);
      chk("R12 reset cmd", {l_cmd, l_addr, l_col, l_ex, l_op}, {8'h00, 40'h0, 16'h0, 1'b1, 8'hFF});

      // R1 chip select does not gate address bytes; command wins over address
      wr(1'b1, 1'b0, 1'b1, 8'h77);
      chk("R1 addr with cs high", l_addr, 40'h77);
      wr(1'b0, 1'b1, 1'b1, 8'h00);
      chk("R1 cmd priority", {l_addr, l_cmd}, {40'h77, 8'h00});
      @(negedge clk);
      chk("R1 idle no strobe", {l_ex, l_unk}, 2'b00);

      // small-page copy: R8 third byte, R3 page offset, R10 plain latch, R11 shift 8
      cmd(8'h00);
      adr(8'h01); adr(8'h02);
      chk("R8 small not yet", s_ex, 1'b0);
      adr(8'h03);
      chk("R8 small third byte", {s_ex, s_op}, {1'b1, 8'h00});
      cmd(8'h50);
      chk("R3 small offset", {s_col, s_cmd}, {16'h0200, 8'h00});
      cmd(8'h30);
      chk("R9 small latches 30", s_cmd, 8'h30);
      cmd(8'h05);
      chk("R10 small latch", {s_cmd, s_ex, s_unk}, {8'h05, 1'b0, 1'b0});
      cmd(8'h60);
      adr(8'h56); adr(8'h78);
      cmd(8'hD0);
      chk("R11 erase small", {s_addr, s_ex, s_op}, {32'h00785600, 1'b1, 8'hD0});

      // large copy on a bigger device: R8 fifth byte
      cmd(8'h80);
      adr(8'h0A); adr(8'h0B); adr(8'h0C); adr(8'h0D);
      chk("R8 big not on fourth", b_ex, 1'b0);
      adr(8'h0E);
      chk("R8 big fifth byte", {b_ex, b_op, b_addr}, {1'b1, 8'h80, 40'h0E0D0C0B0A});

      summary();
      $finish;
   end

endmodule